// File: doc/BRIEF.md
# Byte-Lane Masked Data Memory

A single-port, word-organised data store meant to sit next to a small processor core. Each access is a 32-bit word access. A write changes only the byte lanes whose enable bit is set. A read returns the addressed word on a registered output one clock after the request. The output keeps its previous value through write and idle cycles, so the core can pick the data up whenever it is ready.

Any 32-bit byte address is valid. Only the word-index field just above the two byte-offset bits selects the word. Every other bit is dropped, so addresses outside the array alias back into it. The ready flag is always high because every access completes in the cycle it is issued.

The array has no reset. The active-low reset clears only the read-data register.

Top module: `dmem_top`

## Requirements
- R1: `ready_o` is 1 in every cycle.
- R2: While `rst_ni` is low, and after it is released until the first read, `rdata_o` is 32'h0.
- R3: A cycle with `req_i`=1 and `we_i`=0 at a rising edge puts the addressed word on `rdata_o` after that edge: one cycle of latency.
- R4: A write (`req_i`=1, `we_i`=1) with `be_i`=4'hF replaces the whole addressed word with `wdata_i`.
- R5: On a write, byte lane k (bits 8k+7..8k) of the addressed word takes `wdata_i[8k+7:8k]` only when `be_i[k]`=1. Lanes whose enable bit is 0 keep their contents.
- R6: A write with `be_i`=4'h0 leaves the addressed word unchanged.
- R7: With `req_i`=0, no word changes, whatever `we_i`, `be_i` and `wdata_i` are.
- R8: In any cycle that is not a read (`req_i`=0, or `we_i`=1), `rdata_o` keeps its previous value.
- R9: The word index is `addr_i[2 +: log2(WORDS)]`. Address bits 1:0 and all bits above the index field are ignored, so the index wraps modulo WORDS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset of the read register |
| req_i | input | 1 | Access request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 4 | Byte-lane write enables, bit k for bits 8k+7..8k |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| ready_o | output | 1 | Access complete flag, constant 1 |

## Verification
The properties assume that the control inputs carry known values at every rising edge after reset. They also assume that a full-word write followed by a read of the same index in the next cycle reads back exactly that word, which means no other agent writes the array. The bench meets this by driving every input at the falling edge, from a single process, with defined values. It writes every word before it issues the first read, so no property or check ever compares against an uninitialised location.

// File: rtl/dmem_pkg.sv
`timescale 1ns/1ps
package dmem_pkg;
  parameter int unsigned DMEM_WORDS = 64;
  parameter int unsigned DATA_W     = 32;
  parameter int unsigned ADDR_W     = 32;
  parameter int unsigned LANE_W     = 8;
  localparam int unsigned LANES     = DATA_W / LANE_W;
endpackage

// File: rtl/dmem_addr_fold.sv
`timescale 1ns/1ps
module dmem_addr_fold #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);
  // byte offset and bits above the index field are dropped on purpose
  logic unused_addr_bits;
  assign unused_addr_bits = ^{addr_i[1:0], addr_i[ADDR_W-1:IDX_W+2]};
  assign idx_o = addr_i[2 +: IDX_W];
endmodule

// File: rtl/dmem_req_dec.sv
`timescale 1ns/1ps
module dmem_req_dec #(
  parameter int unsigned LANES = 4
) (
  input  logic             req_i,
  input  logic             we_i,
  input  logic [LANES-1:0] be_i,
  output logic [LANES-1:0] lane_wr_o,
  output logic             rd_o
);
  always_comb begin
    rd_o = req_i && !we_i;
    for (int k = 0; k < LANES; k++) begin
      lane_wr_o[k] = req_i && we_i && be_i[k];
    end
  end
endmodule

// File: rtl/dmem_lane_bank.sv
`timescale 1ns/1ps
module dmem_lane_bank #(
  parameter int unsigned WORDS  = 64,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LANE_W-1:0] wbyte_i,
  output logic [LANE_W-1:0] rbyte_o
);
  logic [LANE_W-1:0] mem_q [WORDS];

  // storage is not reset
  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[idx_i] <= wbyte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rbyte_o <= '0;
    else if (rd_i) rbyte_o <= mem_q[idx_i];
  end
endmodule

// File: rtl/dmem_top.sv
`timescale 1ns/1ps
module dmem_top
  import dmem_pkg::*;
#(
  parameter int unsigned WORDS = DMEM_WORDS,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o
);
  logic [IDX_W-1:0] idx;
  logic [LANES-1:0] lane_wr;
  logic             rd;

  dmem_addr_fold #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fold (
    .addr_i (addr_i),
    .idx_o  (idx)
  );

  dmem_req_dec #(.LANES(LANES)) u_dec (
    .req_i     (req_i),
    .we_i      (we_i),
    .be_i      (be_i),
    .lane_wr_o (lane_wr),
    .rd_o      (rd)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    dmem_lane_bank #(.WORDS(WORDS), .LANE_W(LANE_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (lane_wr[k]),
      .rd_i    (rd),
      .idx_i   (idx),
      .wbyte_i (wdata_i[k*LANE_W +: LANE_W]),
      .rbyte_o (rdata_o[k*LANE_W +: LANE_W])
    );
  end

  // zero wait states
  assign ready_o = 1'b1;
endmodule

// File: rtl/dmem_chk.sv
`timescale 1ns/1ps
module dmem_chk #(
  parameter int unsigned IDX_W = 6
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [3:0]  be_i,
  input logic [31:0] addr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        ready_o
);
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] prev_idx_q;
  logic [31:0]      prev_wdata_q;
  logic             prev_full_wr_q;
  logic             prev_rd_q;

  assign idx = addr_i[2 +: IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_full_wr_q <= 1'b0;
      prev_rd_q      <= 1'b0;
      prev_idx_q     <= '0;
      prev_wdata_q   <= '0;
    end else begin
      prev_full_wr_q <= req_i && we_i && (be_i == 4'hF);
      prev_rd_q      <= req_i && !we_i;
      prev_idx_q     <= idx;
      prev_wdata_q   <= wdata_i;
    end
  end

  p_ready_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o);

  p_rdata_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || we_i) |=> $stable(rdata_o));

  p_full_wr_readback_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && prev_full_wr_q && idx == prev_idx_q) |=> rdata_o == $past(prev_wdata_q));

  p_repeat_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && prev_rd_q && idx == prev_idx_q) |=> $stable(rdata_o));
endmodule

bind dmem_top dmem_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .be_i    (be_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .ready_o (ready_o)
);

// File: tb/dmem_top_tb_top.sv
`timescale 1ns/1ps
module dmem_top_tb_top;
  localparam int WORDS = dmem_pkg::DMEM_WORDS;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  be_i = '0;
  logic [31:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        ready_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] mem_m [WORDS];
  logic [31:0] rd_m = '0;

  dmem_top dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .be_i    (be_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .ready_o (ready_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    logic [7:0] b;
    b = i[7:0];
    return {b ^ 8'h5A, b + 8'h11, ~b, b};
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic do_cycle(input logic req, input logic we, input logic [3:0] be,
                          input logic [31:0] addr, input logic [31:0] wd, input string tag);
    int idx;
    req_i = req; we_i = we; be_i = be; addr_i = addr; wdata_i = wd;
    @(posedge clk_i);
    idx = int'((addr >> 2) % WORDS);
    if (req && we) begin
      for (int k = 0; k < 4; k++) if (be[k]) mem_m[idx][8*k +: 8] = wd[8*k +: 8];
    end else if (req) begin
      rd_m = mem_m[idx];
    end
    @(negedge clk_i);
    check(tag, rdata_o, rd_m);
    check("R1", {31'd0, ready_o}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R2", rdata_o, 32'h0);
    check("R1", {31'd0, ready_o}, 32'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R2", rdata_o, 32'h0);

    // fill every word (R4), output held during writes (R8)
    for (int i = 0; i < WORDS; i++) do_cycle(1, 1, 4'hF, i * 4, pat(i), "R8");
    // read every word back
    for (int i = 0; i < WORDS; i++) do_cycle(1, 0, 4'h0, i * 4, 32'h0, "R4");
    // read latency with back-to-back reads of different words
    for (int i = WORDS - 1; i >= 0; i--) do_cycle(1, 0, 4'h0, i * 4, 32'h0, "R3");

    // every lane mask on its own word (R5, R6 for mask 0)
    for (int b = 0; b < 16; b++) begin
      do_cycle(1, 1, b[3:0], b * 4, 32'hF0E1D2C3 + b, "R8");
      do_cycle(1, 0, 4'h0, b * 4, 32'h0, (b == 0) ? "R6" : "R5");
    end

    // no request: write attempt ignored (R7), output held (R8)
    do_cycle(0, 1, 4'hF, 30 * 4, 32'hDEADBEEF, "R8");
    do_cycle(0, 0, 4'hF, 31 * 4, 32'h0, "R8");
    do_cycle(1, 0, 4'h0, 30 * 4, 32'h0, "R7");

    // aliasing of low and high address bits (R9)
    do_cycle(1, 1, 4'hF, 32'h0010_0000 | (5 * 4) | 3, 32'h1234_5678, "R8");
    do_cycle(1, 0, 4'h0, 5 * 4, 32'h0, "R9");
    do_cycle(1, 0, 4'h0, 32'hFFFF_FF00 | (5 * 4) | 2, 32'h0, "R9");
    do_cycle(1, 1, 4'h3, (WORDS * 4) + 7 * 4 + 1, 32'hAAAA_5555, "R8");
    do_cycle(1, 0, 4'h0, 7 * 4, 32'h0, "R9");

    // mixed random traffic against the shadow model
    for (int n = 0; n < 3000; n++) begin
      logic r, w;
      r = 1'($urandom_range(0, 3) != 0);
      w = 1'($urandom_range(0, 1));
      do_cycle(r, w, 4'($urandom_range(0, 15)), $urandom(), $urandom(),
               (r && !w) ? "R3" : "R8");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule